// File: doc/BRIEF.md
# Paired Byte Queues with Watermarks and Drain

This block holds two byte queues side by side. One carries bytes from the host register port towards the bus sequencer (the outbound queue). The other carries bytes from the sequencer back to the host (the inbound queue). Each queue reports its fill level and its empty and full state. It also reports one watermark flag, compared against a programmable mark.

The outbound watermark flag says "running low" and the inbound one says "filling up". A mark that is larger than the queue can usefully hold is lowered to half the depth minus one.

Software can drain either queue by pulsing a drain request. The block then shows a drain-in-progress bit. Hardware discards one stored entry per clock and drops the bit by itself once the queue is empty. While that bit is high, writes and reads of that queue are ignored.

A write into a full queue is dropped and raises a one-cycle overrun pulse. A read from an empty queue returns zero.

Top module: `dual_byte_queue`

## Requirements
- R1: After reset both queues are empty with level 0, not full, not draining, no overrun pulse, and both read-data outputs are 0.
- R2: Bytes leave a queue in the order they were written. The read-data output is updated on the clock edge that accepts the read, one byte per read strobe.
- R3: The level output counts stored entries. Empty is high when the level is 0. Full is high when the level equals DEPTH (32 by default).
- R4: A write while the queue is full (and not draining) is discarded: the level and the stored bytes are unchanged, and the overrun output is high for exactly the one cycle after that edge.
- R5: A read while the queue is empty returns 0 on the read-data output and leaves the pointers unchanged. A later write followed by a read returns the written byte.
- R6: The outbound low flag is high when the outbound level is less than or equal to the effective outbound mark.
- R7: The inbound high flag is high when the inbound level is greater than or equal to the effective inbound mark.
- R8: The effective mark equals the programmed mark, limited to DEPTH/2-1 (15 for DEPTH 32).
- R9: A drain pulse raises the draining output on the next edge. Stored entries are then discarded one per clock, and draining falls on the edge after the queue reaches empty, so a queue holding N entries reads draining for N+1 sampled cycles.
- R10: While a queue is draining, its write and read strobes take no effect. A read returns 0, a write stores nothing and raises no overrun, and the queue is empty afterwards.
- R11: The two queues are independent: draining one leaves the other's level and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txq_wr_en | input | 1 | Host write strobe, outbound queue |
| txq_wr_byte | input | DW | Host write byte |
| txq_rd_en | input | 1 | Sequencer read strobe, outbound queue |
| txq_rd_byte | output | DW | Byte read by the sequencer (registered) |
| txq_mark | input | TW | Programmed outbound mark |
| txq_flush_go | input | 1 | Drain request pulse, outbound |
| txq_flushing | output | 1 | Outbound drain in progress |
| txq_level | output | $clog2(DEPTH)+1 | Outbound entry count |
| txq_empty | output | 1 | Outbound empty |
| txq_full | output | 1 | Outbound full |
| txq_low | output | 1 | Outbound level at or below effective mark |
| txq_overrun | output | 1 | Outbound write-while-full pulse |
| rxq_wr_en | input | 1 | Sequencer write strobe, inbound queue |
| rxq_wr_byte | input | DW | Sequencer write byte |
| rxq_rd_en | input | 1 | Host read strobe, inbound queue |
| rxq_rd_byte | output | DW | Byte read by the host (registered) |
| rxq_mark | input | TW | Programmed inbound mark |
| rxq_flush_go | input | 1 | Drain request pulse, inbound |
| rxq_flushing | output | 1 | Inbound drain in progress |
| rxq_level | output | $clog2(DEPTH)+1 | Inbound entry count |
| rxq_empty | output | 1 | Inbound empty |
| rxq_full | output | 1 | Inbound full |
| rxq_high | output | 1 | Inbound level at or above effective mark |
| rxq_overrun | output | 1 | Inbound write-while-full pulse |

## Verification
Ordering is checked with short bursts of distinct bytes and with a full 32-entry fill that wraps the pointers. A byte lost or reordered at the wrap shows up there and not in the short case.

Watermark flags are probed at the exact level on each side of the mark, once with a small mark and once with a mark above the limit. This separates a wrong comparison direction from a missing clamp.

Drains are timed on a part-filled queue while the other queue holds data, and strobes are injected mid-drain. This exposes an early or late release, accesses that leak through, and coupling between the two queues.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

  // Highest usable watermark for a queue of the given depth.
  function automatic int unsigned mark_limit(int unsigned depth);
    return depth / 2 - 1;
  endfunction

  // Programmed mark lowered to the usable limit.
  function automatic int unsigned clamp_mark(int unsigned req, int unsigned depth);
    return (req > mark_limit(depth)) ? mark_limit(depth) : req;
  endfunction

  // Watermark comparison; low_side selects "at or below" versus "at or above".
  function automatic logic mark_hit(int unsigned level, int unsigned mark, logic low_side);
    return low_side ? (level <= mark) : (level >= mark);
  endfunction

endpackage

// File: rtl/flush_walker.sv
module flush_walker (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drained,
  output logic busy,
  output logic step
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy <= 1'b0;
    else if (start)           busy <= 1'b1;
    else if (busy && drained) busy <= 1'b0;
  end

  // one discarded entry per cycle while work remains
  assign step = busy && !drained;

endmodule

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int DEPTH    = 32,
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter bit LOW_SIDE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  input  logic [TW-1:0]              mark_cfg,
  input  logic                       flush_set,
  output logic                       flush_busy,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full,
  output logic                       mark_flag,
  output logic                       overrun
);
  import dbq_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [CW-1:0] mark_eff;

  // named internal events
  logic push_ok, pop_ok, walk_step, advance_rd;

  flush_walker u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (flush_set),
    .drained (empty),
    .busy    (flush_busy),
    .step    (walk_step)
  );

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign level      = count;
  assign push_ok    = push && !full && !flush_busy;
  assign pop_ok     = pop && !empty && !flush_busy;
  assign advance_rd = pop_ok || walk_step;
  assign mark_eff   = CW'(clamp_mark(int'(mark_cfg), DEPTH));

  generate
    if (LOW_SIDE) begin : g_low
      assign mark_flag = mark_hit(int'(count), int'(mark_eff), 1'b1);
    end else begin : g_high
      assign mark_flag = mark_hit(int'(count), int'(mark_eff), 1'b0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) store[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      pop_data <= '0;
      overrun  <= 1'b0;
    end else begin
      if (push_ok)    wptr <= wptr + 1'b1;
      if (advance_rd) rptr <= rptr + 1'b1;
      case ({push_ok, advance_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop) pop_data <= pop_ok ? store[rptr] : '0;
      overrun <= push && full && !flush_busy;
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush_busy && !flush_set) |=> full); // R4
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(full)); // R4
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (pop_data == '0)); // R5
  AST_DRAIN_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> empty); // R9
  AST_DRAIN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (count <= $past(count))); // R10

endmodule

// File: rtl/dual_byte_queue.sv
module dual_byte_queue #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txq_wr_en,
  input  logic [DW-1:0]          txq_wr_byte,
  input  logic                   txq_rd_en,
  output logic [DW-1:0]          txq_rd_byte,
  input  logic [TW-1:0]          txq_mark,
  input  logic                   txq_flush_go,
  output logic                   txq_flushing,
  output logic [$clog2(DEPTH):0] txq_level,
  output logic                   txq_empty,
  output logic                   txq_full,
  output logic                   txq_low,
  output logic                   txq_overrun,
  input  logic                   rxq_wr_en,
  input  logic [DW-1:0]          rxq_wr_byte,
  input  logic                   rxq_rd_en,
  output logic [DW-1:0]          rxq_rd_byte,
  input  logic [TW-1:0]          rxq_mark,
  input  logic                   rxq_flush_go,
  output logic                   rxq_flushing,
  output logic [$clog2(DEPTH):0] rxq_level,
  output logic                   rxq_empty,
  output logic                   rxq_full,
  output logic                   rxq_high,
  output logic                   rxq_overrun
);

  byte_queue #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .LOW_SIDE(1'b1)) u_out (
    .clk (clk), .rst_n (rst_n),
    .push (txq_wr_en), .push_data (txq_wr_byte),
    .pop (txq_rd_en), .pop_data (txq_rd_byte),
    .mark_cfg (txq_mark), .flush_set (txq_flush_go), .flush_busy (txq_flushing),
    .level (txq_level), .empty (txq_empty), .full (txq_full),
    .mark_flag (txq_low), .overrun (txq_overrun)
  );

  byte_queue #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .LOW_SIDE(1'b0)) u_in (
    .clk (clk), .rst_n (rst_n),
    .push (rxq_wr_en), .push_data (rxq_wr_byte),
    .pop (rxq_rd_en), .pop_data (rxq_rd_byte),
    .mark_cfg (rxq_mark), .flush_set (rxq_flush_go), .flush_busy (rxq_flushing),
    .level (rxq_level), .empty (rxq_empty), .full (rxq_full),
    .mark_flag (rxq_high), .overrun (rxq_overrun)
  );

endmodule

// File: tb/test_dual_byte_queue.sv
`timescale 1ns/1ps
module test_dual_byte_queue;
  localparam int DEPTH = 32;
  localparam int LIM   = DEPTH / 2 - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txq_wr_en = 0, txq_rd_en = 0, txq_flush_go = 0;
  logic rxq_wr_en = 0, rxq_rd_en = 0, rxq_flush_go = 0;
  logic [7:0] txq_wr_byte = 0, rxq_wr_byte = 0, txq_mark = 0, rxq_mark = 0;
  logic [7:0] txq_rd_byte, rxq_rd_byte;
  logic [5:0] txq_level, rxq_level;
  logic txq_flushing, txq_empty, txq_full, txq_low, txq_overrun;
  logic rxq_flushing, rxq_empty, rxq_full, rxq_high, rxq_overrun;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] txsb[$], rxsb[$];

  always #2.5 clk = ~clk;

  dual_byte_queue i_dual_byte_queue (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tx_put(input logic [7:0] b);
    @(negedge clk); txq_wr_en = 1; txq_wr_byte = b;
    @(negedge clk); txq_wr_en = 0;
    if (txsb.size() < DEPTH) txsb.push_back(b);
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk); rxq_wr_en = 1; rxq_wr_byte = b;
    @(negedge clk); rxq_wr_en = 0;
    if (rxsb.size() < DEPTH) rxsb.push_back(b);
  endtask

  task automatic tx_take(input string req);
    logic [7:0] e;
    e = (txsb.size() > 0) ? txsb.pop_front() : 8'h00;
    @(negedge clk); txq_rd_en = 1;
    @(negedge clk); txq_rd_en = 0;
    chk(txq_rd_byte == e, req, txq_rd_byte, e);
  endtask

  task automatic rx_take(input string req);
    logic [7:0] e;
    e = (rxsb.size() > 0) ? rxsb.pop_front() : 8'h00;
    @(negedge clk); rxq_rd_en = 1;
    @(negedge clk); rxq_rd_en = 0;
    chk(rxq_rd_byte == e, req, rxq_rd_byte, e);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txq_empty && rxq_empty, "R1 empty", {txq_empty, rxq_empty}, 3);
    chk(txq_level == 0 && rxq_level == 0, "R1 level", txq_level + rxq_level, 0);
    chk(!txq_full && !rxq_full && !txq_flushing && !rxq_flushing && !txq_overrun && !rxq_overrun,
        "R1 flags", 1, 0);
    chk(txq_rd_byte == 0 && rxq_rd_byte == 0, "R1 data", txq_rd_byte, 0);

    // R2 / R3 short burst
    tx_put(8'h11); tx_put(8'h22); tx_put(8'hA5); tx_put(8'h5A); tx_put(8'hFF);
    chk(txq_level == 5, "R3 level5", txq_level, 5);
    chk(!txq_empty && !txq_full, "R3 flags5", txq_empty, 0);
    for (int i = 0; i < 5; i++) tx_take("R2 order");
    chk(txq_empty, "R3 empty", txq_empty, 1);

    // R5 empty read
    tx_take("R5 empty read zero");
    tx_put(8'h3C);
    tx_take("R5 pointers intact");
    chk(txq_level == 0, "R5 level", txq_level, 0);

    // R4 fill, overrun, wrap ordering
    for (int i = 0; i < DEPTH; i++) tx_put(8'(i * 7 + 1));
    chk(txq_full && txq_level == DEPTH, "R3 full", txq_level, DEPTH);
    @(negedge clk); txq_wr_en = 1; txq_wr_byte = 8'hEE;
    @(negedge clk); txq_wr_en = 0;
    chk(txq_overrun == 1, "R4 overrun pulse", txq_overrun, 1);
    chk(txq_level == DEPTH, "R4 level kept", txq_level, DEPTH);
    @(negedge clk);
    chk(txq_overrun == 0, "R4 pulse one cycle", txq_overrun, 0);
    for (int i = 0; i < DEPTH; i++) tx_take("R4 contents intact");
    chk(txq_empty, "R4 drained by reads", txq_empty, 1);

    // R6 / R8 outbound mark
    txq_mark = 8'd3;
    for (int i = 0; i < 3; i++) tx_put(8'(i + 8'h40));
    chk(txq_low == 1, "R6 low at mark", txq_low, 1);
    tx_put(8'h43);
    chk(txq_low == 0, "R6 low above mark", txq_low, 0);
    txq_mark = 8'd40;
    for (int i = 4; i < LIM; i++) tx_put(8'(i + 8'h40));
    @(negedge clk);
    chk(txq_level == LIM && txq_low == 1, "R8 tx clamp at limit", txq_low, 1);
    tx_put(8'h99);
    chk(txq_low == 0, "R8 tx clamp above limit", txq_low, 0);
    while (txsb.size() > 5) tx_take("R2 order");

    // R7 / R8 inbound mark
    rxq_mark = 8'd3;
    rx_put(8'hC1); rx_put(8'hC2);
    chk(rxq_high == 0, "R7 below mark", rxq_high, 0);
    rx_put(8'hC3);
    chk(rxq_high == 1, "R7 at mark", rxq_high, 1);
    rxq_mark = 8'd200;
    for (int i = 3; i < LIM - 1; i++) rx_put(8'(i + 8'hD0));
    @(negedge clk);
    chk(rxq_high == 0, "R8 rx clamp below limit", rxq_high, 0);
    rx_put(8'hEF);
    chk(rxq_level == LIM && rxq_high == 1, "R8 rx clamp at limit", rxq_high, 1);

    // R9 / R11 drain inbound while outbound holds 5
    @(negedge clk); rxq_flush_go = 1;
    @(negedge clk); rxq_flush_go = 0;
    chk(rxq_flushing == 1, "R9 draining raised", rxq_flushing, 1);
    cyc = 0;
    while (rxq_flushing && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == LIM + 1, "R9 drain duration", cyc, LIM + 1);
    chk(rxq_empty && rxq_level == 0, "R9 empty after drain", rxq_level, 0);
    rxsb.delete();
    chk(txq_level == 5 && !txq_flushing, "R11 other queue level", txq_level, 5);
    tx_take("R11 other queue contents");

    // R10 strobes during drain
    for (int i = 0; i < 10; i++) rx_put(8'(i + 8'h60));
    @(negedge clk); rxq_flush_go = 1;
    @(negedge clk); rxq_flush_go = 0;
    rxq_wr_en = 1; rxq_wr_byte = 8'hAB; rxq_rd_en = 1;
    @(negedge clk); rxq_wr_en = 0; rxq_rd_en = 0;
    chk(rxq_rd_byte == 0, "R10 read during drain", rxq_rd_byte, 0);
    chk(rxq_overrun == 0, "R10 no overrun", rxq_overrun, 0);
    cyc = 0;
    while (rxq_flushing && cyc < 100) begin @(negedge clk); cyc++; end
    chk(rxq_level == 0, "R10 write during drain ignored", rxq_level, 0);
    rxsb.delete();
    rx_put(8'h77);
    rx_take("R10 queue usable after drain");

    // R9 outbound drain of 4 entries
    @(negedge clk); txq_flush_go = 1;
    @(negedge clk); txq_flush_go = 0;
    cyc = 0;
    while (txq_flushing && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == 5, "R9 outbound drain duration", cyc, 5);
    chk(txq_empty, "R9 outbound empty", txq_empty, 1);
    txsb.delete();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule